// File: doc/BRIEF.md
# Memory Protection Error Capture

This block sits beside one bus port of a memory protection unit. Every cycle it receives, for each of sixteen region descriptors, a hit bit and a violation bit, together with the attributes of the access on the port. These attributes are the process identifier, the master number, whether the master is a processor core, the privilege mode, instruction or data, and read or write. The block judges each access on its own. An access that no descriptor grants is a fault. A fault produces a bus error response, and the first fault is recorded in a 32-bit detail word that software can read.

The detail word keeps a vector that marks each descriptor that was both hit and violated. An all-zero vector therefore tells software that the faulting access hit no region at all. The record is held by a three-state controller with these states:
- `CAP_EMPTY`: nothing is held.
- `CAP_HELD`: one fault is recorded.
- `CAP_OVERRUN`: a fault is recorded and at least one further fault was lost.

The transitions are:
- capture: `CAP_EMPTY` to `CAP_HELD` on a fault.
- overrun: `CAP_HELD` to `CAP_OVERRUN` on a fault without a clear.
- release: `CAP_HELD` or `CAP_OVERRUN` to `CAP_EMPTY` on a clear without a fault.
- recapture: `CAP_HELD` or `CAP_OVERRUN` to `CAP_HELD` on a clear and a fault in the same cycle.

In every other case the state holds. One instance is placed per bus port.

Top module: `prot_err_capture`

## Requirements
- R1: An access (`acc_valid`=1) faults exactly when no descriptor has its hit bit set with its violation bit clear. This covers a miss of every descriptor. An access granted by any hit descriptor passes, whatever the violation bits of other descriptors say.
- R2: `bus_err` is 1 for exactly the one cycle after a faulting access and 0 otherwise. Cycles with `acc_valid`=0 never raise it.
- R3: A fault seen in `CAP_EMPTY` sets `err_valid` on the next cycle. It also loads `err_word[16+d]` with hit AND violation of descriptor d, for d from 0 to 15.
- R4: A faulting access that hit no descriptor is recorded with `err_word[31:16]` all zero.
- R5: `err_word[15:8]` holds the process identifier when `is_core`=1 and zero when `is_core`=0. `err_word[7:4]` holds the master number.
- R6: `err_word[3:1]` holds the attribute code {0, supervisor, data}: 000 user instruction, 001 user data, 010 supervisor instruction, 011 supervisor data. A non-core master is recorded as 011. `err_word[0]` is 1 for a write and 0 for a read.
- R7: While a record is held and `clr_err` is 0, `err_word` and `err_valid` do not change. A further fault sets `err_overrun` on the next cycle.
- R8: `clr_err`=1 in a cycle with no fault clears `err_valid` and `err_overrun` on the next cycle. In `CAP_EMPTY` it has no effect.
- R9: `clr_err`=1 in the same cycle as a fault records the new fault: `err_valid`=1, `err_overrun`=0, and `err_word` holds the new access.
- R10: While `rst_n`=0, and on the first cycle after it, `err_valid`, `err_overrun` and `bus_err` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low synchronous reset |
| acc_valid | input | 1 | an access is presented this cycle |
| hit | input | 16 | per-descriptor region hit |
| viol | input | 16 | per-descriptor permission violation |
| pid | input | 8 | process identifier of the access |
| master | input | 4 | logical master number |
| is_core | input | 1 | master is a processor core |
| supervisor | input | 1 | supervisor (1) or user (0) mode |
| is_data | input | 1 | data (1) or instruction (0) access |
| is_write | input | 1 | write (1) or read (0) |
| clr_err | input | 1 | write-one-to-clear of the held record |
| bus_err | output | 1 | error response, one cycle after a faulting access |
| err_valid | output | 1 | a record is held |
| err_overrun | output | 1 | a further fault was lost while a record was held |
| err_word | output | 32 | error detail word |

## Verification
The fault rule is tried with several access patterns:
- a full miss, which must fault with a zero vector;
- hits that all deny, including a single top descriptor and all sixteen;
- a hit that denies next to one that grants, which must pass;
- violation bits on descriptors that were not hit, which must neither fault nor appear in the vector.

The attribute patterns cover core and non-core masters with each privilege and access-type combination, so the forced identifier and forced attribute code are told apart from the pass-through values. Directed sequences then walk every controller transition. They cover overrun with the record frozen, release, recapture under a simultaneous clear and fault, a clear in the empty state, and a faulting pattern presented with `acc_valid` low.

// File: rtl/prot_err_pkg.sv
package prot_err_pkg;

    localparam int DEF_NUM_DESC = 16;
    localparam int DEF_PID_W    = 8;
    localparam int DEF_MST_W    = 4;
    localparam int ATTR_W       = 3;

    localparam logic [ATTR_W-1:0] ATTR_SUP_DATA = 3'b011;

    typedef enum logic [1:0] {
        CAP_EMPTY   = 2'd0,
        CAP_HELD    = 2'd1,
        CAP_OVERRUN = 2'd2
    } cap_state_e;

endpackage

// File: rtl/prot_err_eval.sv
module prot_err_eval #(
    parameter int NUM_DESC = 16
) (
    input  logic                acc_valid,
    input  logic [NUM_DESC-1:0] hit,
    input  logic [NUM_DESC-1:0] viol,
    output logic                fault,
    output logic [NUM_DESC-1:0] detail_vec
);

    logic [NUM_DESC-1:0] grant;

    for (genvar d = 0; d < NUM_DESC; d++) begin : g_desc
        assign grant[d]      = hit[d] & ~viol[d];
        assign detail_vec[d] = hit[d] &  viol[d];
    end

    // a miss of every region also yields no grant
    assign fault = acc_valid & ~(|grant);

endmodule

// File: rtl/prot_err_format.sv
module prot_err_format
    import prot_err_pkg::*;
#(
    parameter int NUM_DESC = 16,
    parameter int PID_W    = 8,
    parameter int MST_W    = 4,
    localparam int WORD_W  = NUM_DESC + PID_W + MST_W + ATTR_W + 1
) (
    input  logic [NUM_DESC-1:0] detail_vec,
    input  logic [PID_W-1:0]    pid,
    input  logic [MST_W-1:0]    master,
    input  logic                is_core,
    input  logic                supervisor,
    input  logic                is_data,
    input  logic                is_write,
    output logic [WORD_W-1:0]   word
);

    logic [PID_W-1:0]  pid_f;
    logic [ATTR_W-1:0] attr_f;

    always_comb begin
        if (is_core) begin
            pid_f  = pid;
            attr_f = {1'b0, supervisor, is_data};
        end else begin
            pid_f  = '0;
            attr_f = ATTR_SUP_DATA;
        end
    end

    assign word = {detail_vec, pid_f, master, attr_f, is_write};

endmodule

// File: rtl/prot_err_fsm.sv
module prot_err_fsm
    import prot_err_pkg::*;
#(
    parameter int WORD_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fault,
    input  logic              clr_err,
    input  logic [WORD_W-1:0] word_in,
    output logic              bus_err,
    output logic              err_valid,
    output logic              err_overrun,
    output logic [WORD_W-1:0] err_word
);

    cap_state_e state_q, state_d;
    logic       load;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= CAP_EMPTY;
        else        state_q <= state_d;
    end

    // next state and capture strobe
    always_comb begin
        state_d = state_q;
        load    = 1'b0;
        unique case (state_q)
            CAP_EMPTY: begin
                if (fault) begin
                    state_d = CAP_HELD;        // capture
                    load    = 1'b1;
                end
            end
            CAP_HELD: begin
                if (clr_err) begin
                    state_d = fault ? CAP_HELD : CAP_EMPTY; // recapture / release
                    load    = fault;
                end else if (fault) begin
                    state_d = CAP_OVERRUN;     // overrun
                end
            end
            CAP_OVERRUN: begin
                if (clr_err) begin
                    state_d = fault ? CAP_HELD : CAP_EMPTY;
                    load    = fault;
                end
            end
            default: state_d = CAP_EMPTY;
        endcase
    end

    // outputs decoded from state
    always_comb begin
        err_valid   = 1'b0;
        err_overrun = 1'b0;
        unique case (state_q)
            CAP_EMPTY:   ;
            CAP_HELD:    err_valid = 1'b1;
            CAP_OVERRUN: begin
                err_valid   = 1'b1;
                err_overrun = 1'b1;
            end
            default: ;
        endcase
    end

    // detail word holds no reset value
    always_ff @(posedge clk) begin
        if (load) err_word <= word_in;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) bus_err <= 1'b0;
        else        bus_err <= fault;
    end

endmodule

// File: rtl/prot_err_capture.sv
module prot_err_capture
    import prot_err_pkg::*;
#(
    parameter int NUM_DESC = DEF_NUM_DESC,
    parameter int PID_W    = DEF_PID_W,
    parameter int MST_W    = DEF_MST_W,
    localparam int WORD_W  = NUM_DESC + PID_W + MST_W + ATTR_W + 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                acc_valid,
    input  logic [NUM_DESC-1:0] hit,
    input  logic [NUM_DESC-1:0] viol,
    input  logic [PID_W-1:0]    pid,
    input  logic [MST_W-1:0]    master,
    input  logic                is_core,
    input  logic                supervisor,
    input  logic                is_data,
    input  logic                is_write,
    input  logic                clr_err,
    output logic                bus_err,
    output logic                err_valid,
    output logic                err_overrun,
    output logic [WORD_W-1:0]   err_word
);

    logic                fault;
    logic [NUM_DESC-1:0] detail_vec;
    logic [WORD_W-1:0]   word_new;

    prot_err_eval #(.NUM_DESC(NUM_DESC)) u_eval (
        .acc_valid  (acc_valid),
        .hit        (hit),
        .viol       (viol),
        .fault      (fault),
        .detail_vec (detail_vec)
    );

    prot_err_format #(
        .NUM_DESC (NUM_DESC),
        .PID_W    (PID_W),
        .MST_W    (MST_W)
    ) u_format (
        .detail_vec (detail_vec),
        .pid        (pid),
        .master     (master),
        .is_core    (is_core),
        .supervisor (supervisor),
        .is_data    (is_data),
        .is_write   (is_write),
        .word       (word_new)
    );

    prot_err_fsm #(.WORD_W(WORD_W)) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .fault       (fault),
        .clr_err     (clr_err),
        .word_in     (word_new),
        .bus_err     (bus_err),
        .err_valid   (err_valid),
        .err_overrun (err_overrun),
        .err_word    (err_word)
    );

endmodule

// File: rtl/prot_err_capture_chk.sv
module prot_err_capture_chk #(
    parameter int NUM_DESC = 16,
    parameter int PID_W    = 8,
    parameter int MST_W    = 4,
    parameter int WORD_W   = 32
) (
    input logic                clk,
    input logic                rst_n,
    input logic                acc_valid,
    input logic [NUM_DESC-1:0] hit,
    input logic [NUM_DESC-1:0] viol,
    input logic                is_core,
    input logic                clr_err,
    input logic                bus_err,
    input logic                err_valid,
    input logic                err_overrun,
    input logic [WORD_W-1:0]   err_word
);

    logic deny;
    assign deny = acc_valid && ((hit & ~viol) == '0);

    assert_deny_errs_R2: assert property (@(posedge clk) disable iff (!rst_n)
        deny |=> bus_err);

    assert_grant_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !deny |=> !bus_err);

    assert_first_capture_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!err_valid && deny) |=> (err_valid && !err_overrun &&
            err_word[WORD_W-1 -: NUM_DESC] == $past(hit & viol)));

    assert_noncore_attr_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!err_valid && deny && !is_core) |=>
            (err_word[3:1] == 3'b011 && err_word[WORD_W-NUM_DESC-1 -: PID_W] == '0));

    assert_hold_word_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (err_valid && !clr_err) |=> (err_valid && $stable(err_word)));

    assert_overrun_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (err_valid && !clr_err && deny) |=> err_overrun);

    assert_overrun_needs_valid_R7: assert property (@(posedge clk) disable iff (!rst_n)
        err_overrun |-> err_valid);

    assert_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_err && !deny) |=> (!err_valid && !err_overrun));

    assert_recapture_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_err && deny) |=> (err_valid && !err_overrun));

    always @(posedge clk) begin
        if (!rst_n) begin
            assert_reset_R10: assert (!err_valid && !err_overrun)
                else $error("flags set during reset");
        end
    end

endmodule

bind prot_err_capture prot_err_capture_chk #(
    .NUM_DESC (NUM_DESC),
    .PID_W    (PID_W),
    .MST_W    (MST_W),
    .WORD_W   (WORD_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .acc_valid   (acc_valid),
    .hit         (hit),
    .viol        (viol),
    .is_core     (is_core),
    .clr_err     (clr_err),
    .bus_err     (bus_err),
    .err_valid   (err_valid),
    .err_overrun (err_overrun),
    .err_word    (err_word)
);

// File: tb/prot_err_capture_test.sv
module prot_err_capture_test;

    localparam int CLK_PERIOD = 10;
    localparam int NVEC       = 7;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        acc_valid;
    logic [15:0] hit, viol;
    logic [7:0]  pid;
    logic [3:0]  master;
    logic        is_core, supervisor, is_data, is_write, clr_err;
    logic        bus_err, err_valid, err_overrun;
    logic [31:0] err_word;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    prot_err_capture uut (
        .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .hit(hit), .viol(viol),
        .pid(pid), .master(master), .is_core(is_core), .supervisor(supervisor),
        .is_data(is_data), .is_write(is_write), .clr_err(clr_err),
        .bus_err(bus_err), .err_valid(err_valid), .err_overrun(err_overrun),
        .err_word(err_word)
    );

    // {hit, viol, pid, master, core, sup, data, write, fault, word}
    localparam logic [80:0] VEC [NVEC] = '{
        {16'h0000, 16'h0000, 8'h5A, 4'h3, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 32'h00005A32},
        {16'h0011, 16'h0011, 8'h77, 4'h1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 32'h00110017},
        {16'h0011, 16'h0001, 8'h77, 4'h1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 32'h00000000},
        {16'h8000, 16'h8000, 8'hC3, 4'hF, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 32'h8000C3F5},
        {16'h8000, 16'h7FFF, 8'hC3, 4'hF, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 32'h00000000},
        {16'hFFFF, 16'hFFFF, 8'h01, 4'h0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 32'hFFFF0106},
        {16'h0100, 16'h0300, 8'hAB, 4'h2, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 32'h0100AB21}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic present(input logic [80:0] v);
        acc_valid  = 1'b1;
        hit        = v[80:65];
        viol       = v[64:49];
        pid        = v[48:41];
        master     = v[40:37];
        is_core    = v[36];
        supervisor = v[35];
        is_data    = v[34];
        is_write   = v[33];
    endtask

    task automatic idle_bus();
        acc_valid = 1'b0;
        hit = '0; viol = '0; pid = '0; master = '0;
        is_core = 1'b0; supervisor = 1'b0; is_data = 1'b0; is_write = 1'b0;
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic summary();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            summary();
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0;
        clr_err = 1'b0;
        idle_bus();
        repeat (3) @(negedge clk);
        check("R10 valid in reset", {31'd0, err_valid}, 32'd0);
        check("R10 overrun in reset", {31'd0, err_overrun}, 32'd0);
        check("R10 bus_err in reset", {31'd0, bus_err}, 32'd0);
        rst_n = 1'b1;
        step();
        check("R10 flags after reset", {29'd0, bus_err, err_valid, err_overrun}, 32'd0);

        // table walk: R1 R3 R4 R5 R6
        for (int i = 0; i < NVEC; i++) begin
            present(VEC[i]);
            step();
            idle_bus();
            check("R1/R2 bus_err", {31'd0, bus_err}, {31'd0, VEC[i][32]});
            check("R3 err_valid", {31'd0, err_valid}, {31'd0, VEC[i][32]});
            if (VEC[i][32]) check("R4 R5 R6 err_word", err_word, VEC[i][31:0]);
            step();
            check("R2 bus_err single cycle", {31'd0, bus_err}, 32'd0);
            clr_err = 1'b1;
            step();
            clr_err = 1'b0;
            check("R8 cleared", {30'd0, err_valid, err_overrun}, 32'd0);
        end

        // R2: faulting pattern with acc_valid low
        present(VEC[0]);
        acc_valid = 1'b0;
        step();
        idle_bus();
        check("R2 no access no error", {30'd0, bus_err, err_valid}, 32'd0);

        // R8: clear while empty
        clr_err = 1'b1;
        step();
        clr_err = 1'b0;
        check("R8 clear in empty", {29'd0, bus_err, err_valid, err_overrun}, 32'd0);

        // R7: overrun freezes the record
        present(VEC[0]);
        step();
        present(VEC[3]);
        step();
        idle_bus();
        check("R7 second fault bus_err", {31'd0, bus_err}, 32'd1);
        check("R7 overrun set", {30'd0, err_valid, err_overrun}, 32'd3);
        check("R7 word kept", err_word, VEC[0][31:0]);
        step();
        check("R7 still held", err_word, VEC[0][31:0]);

        // R9: clear with simultaneous fault
        present(VEC[6]);
        clr_err = 1'b1;
        step();
        clr_err = 1'b0;
        idle_bus();
        check("R9 recapture flags", {30'd0, err_valid, err_overrun}, 32'd2);
        check("R9 recapture word", err_word, VEC[6][31:0]);

        // R8: release from held
        clr_err = 1'b1;
        step();
        clr_err = 1'b0;
        check("R8 release", {30'd0, err_valid, err_overrun}, 32'd0);

        done = 1'b1;
        summary();
        $finish;
    end

endmodule